// File: doc/BRIEF.md
# Clock Sequence Pattern Player

This block plays back stored clock waveforms onto a bus of 36 digital output lines. These lines carry detector clocks, reset gates and converter controls. A pattern memory of 1024 rows by 36 bits holds the waveforms. Each row is a complete snapshot of all outputs for exactly one sequencer clock cycle, so a hold of n cycles takes n identical rows. A run of n cycles therefore uses n rows of the shared storage. At 15 sequencer cycles per microsecond, a 24-row run lasts 1.6 µs.

Before a run, a controller loads rows through a one-word-per-cycle write port while the player is idle. It then issues a start command with a 10-bit start address and a 10-bit length. The player presents one row per cycle, beginning at the start address. The address advances by one and wraps from 1023 to 0. In the cycle that shows the last row, the player raises a one-cycle done strobe. If a new start arrives in that same cycle, it is taken, and the next sequence follows without a gap.

Between runs, the outputs keep the last row they showed. After reset, they show a parameterised default state, which is the state every stored sequence is written to begin from. Stored sequences normally end on that same state, but the player does not enforce this.

Top module: `clkseq_player`

## Requirements
- R1: After reset, `pins` equals the `DEFAULT_WORD` parameter, `busy` is 0 and `done` is 0.
- R2: When `busy` is 0 and `wr_en` is 1, `wr_data` is stored at row `wr_addr` at the clock edge. A later run that reaches that row shows the stored value.
- R3: A write presented while `busy` is 1, including in the `done` cycle, is discarded. A later run shows the value the row held before.
- R4: A start is accepted when `start` is 1, `start_len` is nonzero, and the player is idle or in its `done` cycle. In the cycle after acceptance, `pins` shows row `start_addr` and `busy` is 1.
- R5: During a run, each later cycle shows the next row at address plus one, modulo 1024, so row 1023 is followed by row 0.
- R6: A run of length L shows exactly L rows. `done` is 1 only in the cycle that shows the L-th row. With L = 1, that is the first cycle of the run.
- R7: When no start is accepted in the `done` cycle, `busy` returns to 0 and `pins` keeps the last row until the next accepted start.
- R8: A start accepted in the `done` cycle makes the very next cycle show the new first row, with `busy` remaining 1.
- R9: A start presented while `busy` is 1 and `done` is 0 is ignored. The current run continues unchanged.
- R10: A start with `start_len` equal to 0 is ignored. `busy` stays 0 and `pins` keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Pattern write request, honoured only when idle |
| wr_addr | input | 10 | Pattern row to write |
| wr_data | input | 36 | Row contents to store |
| start | input | 1 | Start request |
| start_addr | input | 10 | First row of the sequence |
| start_len | input | 10 | Number of rows (cycles) to play; 0 is ignored |
| pins | output | 36 | Driven clock and control lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe on the final row |

## Verification
The bench targets the done-cycle restart. A design that inserted an idle cycle there would drop `busy` and repeat the old last row, and one that missed the restart would stop altogether. It also plays runs that cross address 1023, where a pointer that saturated or reset would show the wrong row. It plays a single-row run, which an off-by-one length counter would stretch to two cycles or leave without a done strobe. Starts and writes are issued mid-run and in the done cycle; a design that honoured them would jump to another address or corrupt the pattern, which the bench then reads back by playback.

// File: rtl/clkseq_player.sv
module clkseq_player #(
  parameter int W  = 36,
  parameter int AW = 10,
  parameter int LW = 10,
  parameter logic [W-1:0] DEFAULT_WORD = 36'h9_5A50_3C0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  output logic [W-1:0]  pins,
  output logic          busy,
  output logic          done
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [LW-1:0] rem;
  logic          go, adv;
  logic [AW-1:0] rd_addr;

  assign done    = busy && (rem == '0);
  assign go      = start && (start_len != '0) && (!busy || done);
  assign adv     = busy && !done;
  assign rd_addr = go ? start_addr : ptr;

  always_ff @(posedge clk) begin
    if (wr_en && !busy) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= DEFAULT_WORD;
      busy <= 1'b0;
      ptr  <= '0;
      rem  <= '0;
    end else begin
      if (go || adv) begin
        pins <= mem[rd_addr];
        ptr  <= rd_addr + 1'b1;
      end
      if (go)       rem <= start_len - 1'b1;
      else if (adv) rem <= rem - 1'b1;
      busy <= go || adv;
    end
  end

endmodule

module clkseq_player_chk #(
  parameter int W  = 36,
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] start_len,
  input logic [W-1:0]  pins,
  input logic          busy,
  input logic          done
);

  p_done_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && start_len == LW'(1))) |=> !done);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && start_len != '0) |=> busy);

  p_run_continues_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && start_len != '0)) |=> ($stable(pins) && !busy));

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && start_len == '0) |=> !busy);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && start_len != '0) |=> busy);

endmodule

bind clkseq_player clkseq_player_chk #(.W(W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
  .pins(pins), .busy(busy), .done(done)
);

// File: tb/clkseq_player_bench.sv
module clkseq_player_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] DEF = 36'h9_5A50_3C0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [35:0] wr_data = '0;
  logic        start = 1'b0;
  logic [9:0]  start_addr = '0;
  logic [9:0]  start_len = '0;
  logic [35:0] pins;
  logic        busy, done;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  clkseq_player #(.DEFAULT_WORD(DEF)) u_clkseq_player (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .start_addr(start_addr), .start_len(start_len),
    .pins(pins), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [35:0] pat(int a);
    return {26'(a * 37 + 5), 10'(a)};
  endfunction

  // behavioural reference
  logic [35:0] m_mem [1024];
  logic [35:0] m_pins = DEF;
  bit m_busy = 0;
  int m_ptr = 0, m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pins = DEF; m_busy = 0; m_ptr = 0; m_left = 0;
    end else begin
      bit fin, take;
      fin  = m_busy && m_left == 0;
      take = start && start_len != 0 && (!m_busy || fin);
      if (wr_en && !m_busy) m_mem[wr_addr] <= wr_data;
      if (take) begin
        m_pins = m_mem[start_addr];
        m_ptr = (int'(start_addr) + 1) % 1024;
        m_left = int'(start_len) - 1;
        m_busy = 1;
      end else if (m_busy && !fin) begin
        m_pins = m_mem[m_ptr];
        m_ptr = (m_ptr + 1) % 1024;
        m_left = m_left - 1;
      end else begin
        m_busy = 0;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, {26'd0, m_busy, (m_busy && m_left == 0), pins}, {26'd0, busy, done, m_pins});
      chk(cur_req, {28'd0, pins}, {28'd0, m_pins});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic go(int a, int len);
    start = 1; start_addr = 10'(a); start_len = 10'(len);
    tick();
    start = 0;
  endtask

  task automatic wait_done();
    while (!done) tick();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int ndone;
    #(CLK_PERIOD * 3);
    chk("R1", {27'd0, busy, pins}, {27'd0, 1'b0, DEF});
    chk("R1", {63'd0, done}, 64'd0);
    @(negedge clk); rst_n = 1;
    tick();

    cur_req = "R2";
    for (int a = 0; a < 1024; a++) begin
      wr_en = 1; wr_addr = 10'(a); wr_data = pat(a);
      tick();
    end
    wr_en = 0;

    cur_req = "R4";
    go(2, 5);
    chk("R4", {28'd0, pins}, {28'd0, pat(2)});
    chk("R4", {63'd0, busy}, 64'd1);
    cur_req = "R6";
    ndone = 0;
    for (int i = 0; i < 6; i++) begin
      if (done) ndone++;
      if (i == 4) chk("R6", {63'd0, done}, 64'd1);
      tick();
    end
    chk("R6", 64'(ndone), 64'd1);
    cur_req = "R7";
    chk("R7", {27'd0, busy, pins}, {27'd0, 1'b0, pat(6)});
    repeat (3) tick();
    chk("R7", {28'd0, pins}, {28'd0, pat(6)});

    cur_req = "R5";
    go(1020, 6);
    repeat (4) tick();
    chk("R5", {28'd0, pins}, {28'd0, pat(0)});
    wait_done();
    chk("R5", {28'd0, pins}, {28'd0, pat(1)});
    tick();

    cur_req = "R6";
    go(7, 1);
    chk("R6", {63'd0, done}, 64'd1);
    chk("R6", {28'd0, pins}, {28'd0, pat(7)});
    tick();
    chk("R6", {63'd0, busy}, 64'd0);

    cur_req = "R8";
    go(0, 3);
    wait_done();
    start = 1; start_addr = 10'd8; start_len = 10'd2;
    tick(); start = 0;
    chk("R8", {27'd0, busy, pins}, {27'd0, 1'b1, pat(8)});
    chk("R8", {63'd0, done}, 64'd0);
    wait_done(); tick();

    cur_req = "R9";
    go(20, 8);
    tick();
    go(500, 2);
    chk("R9", {28'd0, pins}, {28'd0, pat(22)});
    wait_done();
    chk("R9", {28'd0, pins}, {28'd0, pat(27)});
    tick();

    cur_req = "R3";
    go(30, 4);
    wr_en = 1; wr_addr = 10'd3; wr_data = 36'hF_FFFF_0000;
    tick();
    wr_addr = 10'd4;
    wait_done();
    wr_addr = 10'd5;
    tick(); wr_en = 0;
    go(3, 3);
    chk("R3", {28'd0, pins}, {28'd0, pat(3)});
    tick(); chk("R3", {28'd0, pins}, {28'd0, pat(4)});
    tick(); chk("R3", {28'd0, pins}, {28'd0, pat(5)});
    tick();

    cur_req = "R2";
    wr_en = 1; wr_addr = 10'd9; wr_data = 36'hA_BCDE_1234;
    tick(); wr_en = 0;
    go(9, 1);
    chk("R2", {28'd0, pins}, {28'd0, 36'hA_BCDE_1234});
    tick();

    cur_req = "R10";
    go(40, 0);
    chk("R10", {27'd0, busy, pins}, {27'd0, 1'b0, 36'hA_BCDE_1234});
    tick();

    cur_req = "R5";
    go(600, 1023);
    wait_done();
    chk("R5", {28'd0, pins}, {28'd0, pat(598)});
    repeat (2) tick();

    report();
  end
endmodule